// File: doc/BRIEF.md
# DMA Interrupt Pending and Enable Unit

This unit holds the shared interrupt state of a multi-channel DMA controller. Each channel engine reports two kinds of event as one-cycle pulses: a transfer-complete pulse and a half-complete pulse. The unit latches every pulse into a pending bit, whether or not that bit is enabled. Software reads the pending word, clears bits by writing ones to them, and selects which bits may raise an interrupt through a separate enable word.

Both words sit on a simple 32-bit register port. The pending word is at byte offset 0 and the enable word is at byte offset 4. Within each word, the transfer-complete bit of channel n is bit n, and the half-complete bit is bit n+16. Each channel drives its own registered interrupt line. The line is high when either of that channel's two bits is both pending and enabled.

Reads are combinational from the address. Writes take effect when both the strobe and the write flag are high.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the pending word, the enable word and every irq_o line are zero.
- R2: A pulse on tc_evt_i[n] sets pending bit n, and a pulse on hc_evt_i[n] sets pending bit n+16, whatever the enable word holds.
- R3: A write to offset 0 clears each pending bit whose write-data bit is 1; bits written with 0 keep their value.
- R4: If an event pulse and a write of 1 to the same pending bit fall in the same cycle, that bit is set afterwards.
- R5: The enable word at offset 4 is a plain read/write register; a write replaces it and a read returns the stored value.
- R6: irq_o[n] equals, one clock after the register state, the OR of (pending AND enable) over bits n and n+16.
- R7: Pending and enable bits of channels at or above NUM_CH read as zero, and writes to them have no effect.
- R8: A write with reg_en_i low, or to any offset other than 0 or 4, changes nothing; reads of other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write flag, qualified by reg_en_i |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tc_evt_i | input | NUM_CH | Transfer-complete pulse per channel |
| hc_evt_i | input | NUM_CH | Half-complete pulse per channel |
| irq_o | output | NUM_CH | Registered interrupt line per channel |

## Verification
The bench builds the unit with NUM_CH set to 6. With that setting, bits 6 to 15 and 22 to 31 of both words belong to absent channels. The bench can then show that all-ones writes leave those bits at zero, while the six live channels still exercise both word halves. A random phase of several hundred cycles mixes sparse event pulses with clears, enable rewrites and stray-offset writes. Each cycle of that phase is compared against a bench model of the pending, enable and interrupt state.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W    = 32;
  localparam int HALF_W   = 16;
  localparam int MAX_CH   = 16;
  localparam int OFS_PEND = 0;
  localparam int OFS_EN   = 4;

  // bits n and n+16 are live for every channel n < n_ch
  function automatic logic [REG_W-1:0] impl_mask(input int n_ch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (i < n_ch) begin
        m[i]          = 1'b1;
        m[i + HALF_W] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_irq_pend.sv
module dma_irq_pend
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tc_evt_i,
  input  logic [NUM_CH-1:0] hc_evt_i,
  input  logic [REG_W-1:0]  clr_i,
  output logic [REG_W-1:0]  pend_o
);
  localparam logic [REG_W-1:0] LIVE = impl_mask(NUM_CH);

  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] pend_q;

  for (genvar i = 0; i < HALF_W; i++) begin : g_evt
    if (i < NUM_CH) begin : g_live
      assign evt_vec[i]          = tc_evt_i[i];
      assign evt_vec[i + HALF_W] = hc_evt_i[i];
    end else begin : g_dead
      assign evt_vec[i]          = 1'b0;
      assign evt_vec[i + HALF_W] = 1'b0;
    end
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_i) | evt_vec) & LIVE;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_irq_en.sv
module dma_irq_en
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  localparam logic [REG_W-1:0] LIVE = impl_mask(NUM_CH);

  logic [REG_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & LIVE;
  end

  assign en_o = en_q;
endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  act_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[c] <= 1'b0;
      else         irq_q[c] <= act_i[c] | act_i[c + HALF_W];
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] tc_evt_i,
  input  logic [NUM_CH-1:0] hc_evt_i,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

  logic             wr;
  logic             sel_pend;
  logic             sel_en;
  logic [REG_W-1:0] clr;
  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] en_q;

  assign wr       = reg_en_i & reg_we_i;
  assign sel_pend = (reg_addr_i == A_PEND);
  assign sel_en   = (reg_addr_i == A_EN);
  assign clr      = (wr && sel_pend) ? reg_wdata_i : '0;

  dma_irq_pend #(.NUM_CH(NUM_CH)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tc_evt_i (tc_evt_i),
    .hc_evt_i (hc_evt_i),
    .clr_i    (clr),
    .pend_o   (pend_q)
  );

  dma_irq_en #(.NUM_CH(NUM_CH)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && sel_en),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q)
  );

  dma_irq_out #(.NUM_CH(NUM_CH)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (pend_q & en_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    if (sel_pend)    reg_rdata_o = pend_q;
    else if (sel_en) reg_rdata_o = en_q;
    else             reg_rdata_o = '0;
  end
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [NUM_CH-1:0] tc_evt_i,
  input logic [NUM_CH-1:0] hc_evt_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [31:0]       pend_q,
  input logic [31:0]       en_q
);
  localparam logic [31:0] LIVE = impl_mask(NUM_CH);

  logic [31:0] ev;
  logic        wr_pend;

  always_comb begin
    ev = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ev[i]      = tc_evt_i[i];
      ev[i + 16] = hc_evt_i[i];
    end
  end

  assign wr_pend = reg_en_i && reg_we_i && (reg_addr_i == ADDR_W'(OFS_PEND));

  // R2
  evt_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((pend_q & $past(ev)) == $past(ev)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend && ev == '0) |=> ((pend_q & $past(reg_wdata_i)) == '0));

  // R4
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend && (reg_wdata_i & ev) != '0)
      |=> ((pend_q & $past(reg_wdata_i & ev)) == $past(reg_wdata_i & ev)));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(en_q) != '0));

  // R6
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & en_q) == '0) |=> (irq_o == '0));

  // R7
  dead_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pend_q | en_q) & ~LIVE) == '0));
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tc_evt_i    (tc_evt_i),
  .hc_evt_i    (hc_evt_i),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .en_q        (en_q)
);

// File: tb/dma_irq_unit_bench.sv
module dma_irq_unit_bench;
  localparam int NCH = 6;
  localparam int AW  = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_en_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [NCH-1:0] tc_evt_i = '0;
  logic [NCH-1:0] hc_evt_i = '0;
  logic [NCH-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0]    pm = '0;
  logic [31:0]    em = '0;
  logic [NCH-1:0] im = '0;

  always #5 clk_i = ~clk_i;

  dma_irq_unit #(.NUM_CH(NCH), .ADDR_W(AW)) u_dma_irq_unit (
    .clk_i, .rst_ni, .reg_en_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .tc_evt_i, .hc_evt_i, .irq_o
  );

  function automatic logic [31:0] live();
    logic [31:0] m = '0;
    for (int i = 0; i < NCH; i++) begin
      m[i] = 1'b1;
      m[i + 16] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] pack_ev(input logic [NCH-1:0] tc, input logic [NCH-1:0] hc);
    logic [31:0] v = '0;
    for (int i = 0; i < NCH; i++) begin
      v[i] = tc[i];
      v[i + 16] = hc[i];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock edge with given inputs; model updated from pre-edge state
  task automatic tick(input logic en, input logic we, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [NCH-1:0] tc, input logic [NCH-1:0] hc);
    logic [31:0] act;
    logic [31:0] clr;
    @(negedge clk_i);
    reg_en_i = en; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    tc_evt_i = tc; hc_evt_i = hc;
    @(posedge clk_i);
    act = pm & em;
    for (int k = 0; k < NCH; k++) im[k] = act[k] | act[k + 16];
    clr = (en && we && a == 4'd0) ? wd : '0;
    pm = ((pm & ~clr) | pack_ev(tc, hc)) & live();
    if (en && we && a == 4'd4) em = wd & live();
    #1;
    reg_en_i = 1'b0; reg_we_i = 1'b0; tc_evt_i = '0; hc_evt_i = '0;
  endtask

  task automatic check_all(input string tag);
    reg_addr_i = 4'd0; #1;
    chk({tag, " pending"}, reg_rdata_o, pm);
    reg_addr_i = 4'd4; #1;
    chk({tag, " enable"}, reg_rdata_o, em);
    chk({tag, " irq"}, 32'(irq_o), 32'(im));
    reg_addr_i = 4'd8; #1;
    chk({tag, " R8 stray read"}, reg_rdata_o, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_all("R1 reset");

    // R2: events latch with enables off, no irq
    tick(0, 0, 0, 0, 6'b000100, 6'b0);
    check_all("R2 tc ch2");
    tick(0, 0, 0, 0, 6'b0, 6'b100000);
    check_all("R2 hc ch5");
    tick(0, 0, 0, 0, 6'b0, 6'b0);
    check_all("R2 irq stays low");

    // R3: zeros keep, ones clear
    tick(1, 1, 4'd0, 32'h0, 0, 0);
    check_all("R3 write zero");
    tick(1, 1, 4'd0, 32'h0000_0004, 0, 0);
    check_all("R3 clear bit2");

    // R4: set beats clear
    tick(1, 1, 4'd0, 32'h0020_0000, 0, 6'b100000);
    check_all("R4 collide");

    // R5/R7: all-ones enable keeps only live bits
    tick(1, 1, 4'd4, 32'hFFFF_FFFF, 0, 0);
    check_all("R5 R7 enable all");
    tick(0, 0, 0, 0, 0, 0);
    check_all("R6 irq hc ch5");
    tick(1, 1, 4'd4, 32'h0000_0001, 6'b000001, 0);
    check_all("R5 enable tc ch0");
    tick(0, 0, 0, 0, 0, 0);
    check_all("R6 irq tc ch0");

    // R7: pending write of ones cannot set dead bits
    tick(1, 1, 4'd0, 32'hFFC0_FFC0, 0, 0);
    check_all("R7 dead pending");

    // R8: gated or stray writes
    tick(0, 1, 4'd4, 32'h0, 0, 0);
    check_all("R8 strobe low");
    tick(1, 1, 4'd8, 32'hFFFF_FFFF, 0, 0);
    check_all("R8 stray offset");
    tick(1, 1, 4'd12, 32'hFFFF_FFFF, 0, 0);
    check_all("R8 stray offset 12");

    for (int n = 0; n < 400; n++) begin
      logic [3:0]     sel;
      logic [NCH-1:0] tc;
      logic [NCH-1:0] hc;
      logic [AW-1:0]  a;
      sel = 4'($urandom_range(0, 15));
      tc  = NCH'($urandom) & NCH'($urandom);
      hc  = NCH'($urandom) & NCH'($urandom);
      a   = (sel < 6) ? 4'd0 : (sel < 9) ? 4'd4 : 4'(2 * $urandom_range(4, 7));
      tick(sel != 4'd15, sel < 12, a, $urandom, tc, hc);
      check_all("R2 R3 R6 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule